// File: doc/BRIEF.md
# SPI Slave Register Access Front-End

This block lets an external SPI master read and write an internal 64 KB, byte-addressed register space. Every frame opens with an address/command header. The bridge decodes that header, then turns each following data byte into one access on a synchronous request/acknowledge register bus.

A two-byte header reaches the low 8 KB of the space. A special command code in the second byte extends the header by a third byte, and that third byte carries the top three address bits and the real command. While the header bytes are being clocked in, the bridge returns interrupt-request status bytes on MISO. After the header, a burst continues for as long as chip select stays low. During a burst the address moves up by one for each byte and wraps from 0xFFFF to 0x0000.

The SPI pins are sampled by the system clock, which must be much faster than SCLK. The SPI mode is clock-idle-low, data sampled on the rising edge and MSB first.

The frame controller has these states:
- F_IDLE: deselected.
- F_ADDR_HI: header byte 0.
- F_ADDR_LO: header byte 1.
- F_ADDR_EXT: extension byte.
- F_RD: read burst.
- F_WR: write burst.
- F_SKIP: no-operation or reserved command.

Its transitions are:
- F_IDLE to F_ADDR_HI when chip select is low.
- F_ADDR_HI to F_ADDR_LO when a byte completes.
- F_ADDR_LO to F_ADDR_EXT on command 110, to F_RD on 010, to F_WR on 100, and to F_SKIP on any other code.
- F_ADDR_EXT to F_RD or F_WR on a valid second command with the reserved bits at 00, and to F_SKIP otherwise.
- Any state to F_IDLE whenever chip select is high.

The bus master has two states. B_IDLE moves to B_BUSY when a read or write is launched. B_BUSY returns to B_IDLE on acknowledge or on deselect.

Top module: `spi_reg_bridge`

## Requirements
- R1: The SPI timing is mode 0, MSB first. MOSI is sampled on SCLK rising edges. MISO changes only while SCLK is low: on the falling edge, or on selection. Each SCLK phase lasts at least 8 system clocks, and the bus acknowledges within one cycle of a request.
- R2: Header byte 0 holds address bits [12:5]. Header byte 1 holds address bits [4:0] in bits [7:3] and a command in bits [2:0]. The command codes are 000 no operation, 010 read, 100 write and 110 extend. Every other code is reserved.
- R3: With a two-byte header, address bits [15:13] are 000. Data starts at byte 2.
- R4: After command 110, byte 2 carries address [15:13] in bits [7:5], a second command in bits [4:2] and reserved bits [1:0]. An access happens only if those reserved bits are 00 and the second command is read or write. Data starts at byte 3.
- R5: MISO returns interrupt bytes during the header: irq_flags[7:0] in byte 0, irq_flags[15:8] in byte 1 and irq_flags[23:16] in byte 2 of an extended header. All three are taken as one snapshot at selection.
- R6: In a read burst, data byte n returns the register at start address + n, modulo 65536. Register data is fetched ahead of time so that MISO never waits.
- R7: In a write burst, data byte n is written to start address + n, modulo 65536. Only complete bytes are written, and a partial byte at deselect is dropped.
- R8: With a no-operation or reserved command there is no bus access, and MISO sends 0x00 in the data phase.
- R9: During a write burst MISO sends 0x00.
- R10: Deselecting at any point ends the frame. The next frame is parsed from header byte 0.
- R11: A bus request holds its address, direction and write data until it is acknowledged. The request drops after the acknowledge, and no request is pending while the bridge is deselected.
- R12: After reset, and whenever the bridge is deselected, MISO is low and there is no bus request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI clock, idle low |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| irq_flags | input | 24 | Interrupt status bytes, lowest byte sent first |
| bus_req | output | 1 | Register bus request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Register byte address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with bus_ack |
| bus_ack | input | 1 | Acknowledge, one cycle |

## Verification
The bench sweeps a single set address bit through each header position in both header forms. A design with a mis-sliced address field, or one that leaks header bits into [15:13] in short mode, returns the wrong register data. It runs bursts across 0xFFFF for both reads and writes, which a design without wrap-around would send to 0x10000 or stop. It walks all eight command codes, and sends extension bytes with bad reserved bits or a nested extend code, to catch accesses that should not happen. It also changes the interrupt inputs in the middle of a header to expose a missing snapshot, and deselects mid-byte and mid-header to catch stray partial writes and a parser that resumes at the wrong byte.

// File: rtl/srb_pkg.sv
package srb_pkg;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 16;
    localparam int CMD_W   = 3;
    localparam int EXT_W   = ADDR_W - BYTE_W - (BYTE_W - CMD_W);
    localparam int RES_W   = BYTE_W - EXT_W - CMD_W;
    localparam int IRQ_N   = 3;

    localparam logic [CMD_W-1:0] CMD_NOP = 3'b000;
    localparam logic [CMD_W-1:0] CMD_RD  = 3'b010;
    localparam logic [CMD_W-1:0] CMD_WR  = 3'b100;
    localparam logic [CMD_W-1:0] CMD_EXT = 3'b110;

    typedef enum logic [2:0] {
        F_IDLE,
        F_ADDR_HI,
        F_ADDR_LO,
        F_ADDR_EXT,
        F_RD,
        F_WR,
        F_SKIP
    } frame_state_t;

    typedef enum logic {
        B_IDLE,
        B_BUSY
    } bus_state_t;
endpackage

// File: rtl/srb_bit_engine.sv
module srb_bit_engine #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              mosi,
    input  logic [BYTE_W-1:0] first_tx,
    input  logic [BYTE_W-1:0] next_tx,
    output logic              miso,
    output logic              cs_start,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              tx_loaded
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic              sclk_q;
    logic              cs_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              rise;
    logic              fall;

    assign cs_start = cs_q & ~cs_n;
    assign rise     = ~cs_n & sclk & ~sclk_q;
    assign fall     = ~cs_n & ~sclk & sclk_q;
    assign miso     = cs_n ? 1'b0 : tx_sh[BYTE_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q    <= 1'b0;
            cs_q      <= 1'b1;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
            tx_loaded <= 1'b0;
        end else begin
            sclk_q    <= sclk;
            cs_q      <= cs_n;
            byte_done <= 1'b0;
            tx_loaded <= 1'b0;
            if (cs_n) begin
                bit_cnt <= '0;
            end else if (cs_start) begin
                bit_cnt <= '0;
                tx_sh   <= first_tx;
            end else begin
                if (rise) begin
                    rx_sh <= {rx_sh[BYTE_W-3:0], mosi};
                    if (bit_cnt == LAST_BIT) begin
                        bit_cnt   <= '0;
                        byte_done <= 1'b1;
                        rx_byte   <= {rx_sh, mosi};
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                if (fall) begin
                    if (bit_cnt == '0) begin
                        tx_sh     <= next_tx;
                        tx_loaded <= 1'b1;
                    end else begin
                        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/srb_bus_master.sv
module srb_bus_master
    import srb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              rd_go,
    input  logic              wr_go,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              bus_ack,
    input  logic [BYTE_W-1:0] bus_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BYTE_W-1:0] bus_wdata,
    output logic              rd_done,
    output logic              wr_done,
    output logic [BYTE_W-1:0] rd_data
);
    bus_state_t state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= B_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        if (abort) begin
            state_nxt = B_IDLE;
        end else begin
            unique case (state)
                B_IDLE: if (rd_go || wr_go) state_nxt = B_BUSY;
                B_BUSY: if (bus_ack)        state_nxt = B_IDLE;
                default:                    state_nxt = B_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else if (state == B_IDLE && !abort && (rd_go || wr_go)) begin
            bus_we    <= wr_go;
            bus_addr  <= addr;
            bus_wdata <= wdata;
        end
    end

    assign bus_req = (state == B_BUSY);
    assign rd_done = bus_req & bus_ack & ~bus_we;
    assign wr_done = bus_req & bus_ack & bus_we;
    assign rd_data = bus_rdata;
endmodule

// File: rtl/srb_frame_ctrl.sv
module srb_frame_ctrl
    import srb_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_n,
    input  logic                      cs_start,
    input  logic                      byte_done,
    input  logic [BYTE_W-1:0]         rx_byte,
    input  logic                      tx_loaded,
    input  logic [(IRQ_N-1)*BYTE_W-1:0] irq_upper,
    input  logic                      rd_done,
    input  logic                      wr_done,
    input  logic [BYTE_W-1:0]         rd_data,
    output logic [BYTE_W-1:0]         next_tx,
    output logic [ADDR_W-1:0]         addr,
    output logic [BYTE_W-1:0]         wdata,
    output logic                      rd_go,
    output logic                      wr_go
);
    localparam int LO_W = BYTE_W - CMD_W;

    frame_state_t state, state_nxt;
    logic [BYTE_W-1:0]           hi_byte;
    logic [(IRQ_N-1)*BYTE_W-1:0] snap;
    logic [CMD_W-1:0]            cmd_lo;
    logic [CMD_W-1:0]            cmd_ext;
    logic [RES_W-1:0]            res_ext;
    logic                        ext_ok_rd;
    logic                        ext_ok_wr;

    assign cmd_lo    = rx_byte[CMD_W-1:0];
    assign cmd_ext   = rx_byte[RES_W +: CMD_W];
    assign res_ext   = rx_byte[RES_W-1:0];
    assign ext_ok_rd = (res_ext == '0) && (cmd_ext == CMD_RD);
    assign ext_ok_wr = (res_ext == '0) && (cmd_ext == CMD_WR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= F_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        if (cs_n) begin
            state_nxt = F_IDLE;
        end else begin
            unique case (state)
                F_IDLE:    state_nxt = F_ADDR_HI;
                F_ADDR_HI: if (byte_done) state_nxt = F_ADDR_LO;
                F_ADDR_LO: begin
                    if (byte_done) begin
                        if      (cmd_lo == CMD_EXT) state_nxt = F_ADDR_EXT;
                        else if (cmd_lo == CMD_RD)  state_nxt = F_RD;
                        else if (cmd_lo == CMD_WR)  state_nxt = F_WR;
                        else                        state_nxt = F_SKIP;
                    end
                end
                F_ADDR_EXT: begin
                    if (byte_done) begin
                        if      (ext_ok_rd) state_nxt = F_RD;
                        else if (ext_ok_wr) state_nxt = F_WR;
                        else                state_nxt = F_SKIP;
                    end
                end
                F_RD, F_WR, F_SKIP: state_nxt = state;
                default:            state_nxt = F_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_byte <= '0;
            snap    <= '0;
            next_tx <= '0;
            addr    <= '0;
            wdata   <= '0;
            rd_go   <= 1'b0;
            wr_go   <= 1'b0;
        end else begin
            rd_go <= 1'b0;
            wr_go <= 1'b0;
            if (cs_start) snap <= irq_upper;
            if (!cs_n) begin
                unique case (state)
                    F_IDLE: ;
                    F_ADDR_HI: begin
                        if (byte_done) begin
                            hi_byte <= rx_byte;
                            next_tx <= snap[BYTE_W-1:0];
                        end
                    end
                    F_ADDR_LO: begin
                        if (byte_done) begin
                            addr    <= {EXT_W'(0), hi_byte, rx_byte[BYTE_W-1 -: LO_W]};
                            next_tx <= (cmd_lo == CMD_EXT) ? snap[BYTE_W +: BYTE_W] : '0;
                            rd_go   <= (cmd_lo == CMD_RD);
                        end
                    end
                    F_ADDR_EXT: begin
                        if (byte_done) begin
                            addr[ADDR_W-1 -: EXT_W] <= rx_byte[BYTE_W-1 -: EXT_W];
                            next_tx <= '0;
                            rd_go   <= ext_ok_rd;
                        end
                    end
                    F_RD: begin
                        if (rd_done) next_tx <= rd_data;
                        if (tx_loaded) begin
                            addr  <= addr + 1'b1;
                            rd_go <= 1'b1;
                        end
                    end
                    F_WR: begin
                        next_tx <= '0;
                        if (byte_done) begin
                            wdata <= rx_byte;
                            wr_go <= 1'b1;
                        end
                        if (wr_done) addr <= addr + 1'b1;
                    end
                    F_SKIP:  next_tx <= '0;
                    default: next_tx <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge
    import srb_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_n,
    input  logic                      sclk,
    input  logic                      mosi,
    output logic                      miso,
    input  logic [IRQ_N*BYTE_W-1:0]   irq_flags,
    output logic                      bus_req,
    output logic                      bus_we,
    output logic [ADDR_W-1:0]         bus_addr,
    output logic [BYTE_W-1:0]         bus_wdata,
    input  logic [BYTE_W-1:0]         bus_rdata,
    input  logic                      bus_ack
);
    logic              cs_start;
    logic              byte_done;
    logic              tx_loaded;
    logic [BYTE_W-1:0] rx_byte;
    logic [BYTE_W-1:0] next_tx;
    logic [ADDR_W-1:0] acc_addr;
    logic [BYTE_W-1:0] acc_wdata;
    logic              rd_go;
    logic              wr_go;
    logic              rd_done;
    logic              wr_done;
    logic [BYTE_W-1:0] rd_data;

    srb_bit_engine #(.BYTE_W(BYTE_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .mosi      (mosi),
        .first_tx  (irq_flags[BYTE_W-1:0]),
        .next_tx   (next_tx),
        .miso      (miso),
        .cs_start  (cs_start),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .tx_loaded (tx_loaded)
    );

    srb_frame_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .cs_start  (cs_start),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .tx_loaded (tx_loaded),
        .irq_upper (irq_flags[IRQ_N*BYTE_W-1:BYTE_W]),
        .rd_done   (rd_done),
        .wr_done   (wr_done),
        .rd_data   (rd_data),
        .next_tx   (next_tx),
        .addr      (acc_addr),
        .wdata     (acc_wdata),
        .rd_go     (rd_go),
        .wr_go     (wr_go)
    );

    srb_bus_master u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (cs_n),
        .rd_go     (rd_go),
        .wr_go     (wr_go),
        .addr      (acc_addr),
        .wdata     (acc_wdata),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .rd_done   (rd_done),
        .wr_done   (wr_done),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/srb_checker.sv
module srb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        sclk,
    input logic        miso,
    input logic        bus_req,
    input logic        bus_we,
    input logic [15:0] bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        bus_ack
);
    // R12: deselected bridge keeps MISO low
    p_miso_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !miso);

    // R11: deselect clears any pending request by the next cycle
    p_no_req_deselected_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !bus_req);

    // R11: unacknowledged request keeps its fields
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !cs_n) |=>
            (cs_n || (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata))));

    // R11: request drops after acknowledge
    p_ack_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> !bus_req);

    // R1: MISO is steady through an SCLK high phase
    p_miso_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n) && sclk && $past(sclk)) |-> $stable(miso));
endmodule

bind spi_reg_bridge srb_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .miso      (miso),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack)
);

// File: tb/spi_reg_bridge_tb.sv
module spi_reg_bridge_tb;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        mosi = 1'b0;
    logic        miso;
    logic [23:0] irq_flags = 24'h0;
    logic        bus_req;
    logic        bus_we;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        bus_ack;

    int n_chk = 0;
    int n_fail = 0;
    int n_wr = 0;
    int n_rd = 0;
    bit finished = 0;

    logic [15:0] wr_addr_log [64];
    logic [7:0]  wr_data_log [64];
    logic [7:0]  tx_buf [8];
    logic [7:0]  rx_buf [8];
    logic [7:0]  hdr_rx [3];
    logic [23:0] irq_start;

    always #5 clk = ~clk;

    spi_reg_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso),
        .irq_flags(irq_flags), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    function automatic logic [7:0] model_rd(input logic [15:0] a);
        return {a[3:0], a[7:4]} ^ a[15:8] ^ 8'h5A;
    endfunction

    assign bus_rdata = model_rd(bus_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_ack <= 1'b0;
        else        bus_ack <= bus_req & ~bus_ack;
    end

    always @(posedge clk) begin
        if (rst_n && bus_req && bus_ack) begin
            if (bus_we) begin
                if (n_wr < 64) begin
                    wr_addr_log[n_wr] <= bus_addr;
                    wr_data_log[n_wr] <= bus_wdata;
                end
                n_wr <= n_wr + 1;
            end else begin
                n_rd <= n_rd + 1;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int n);
        for (int i = 7; i >= 8 - n; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic cs_begin();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_end();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic run_frame(input bit ext, input logic [15:0] a, input logic [2:0] cmd,
                             input logic [1:0] res, input int n, input int tail);
        logic [7:0] r;
        irq_start = irq_flags;
        cs_begin();
        spi_byte(a[12:5], r);
        hdr_rx[0] = r;
        irq_flags = irq_flags ^ 24'hFFFFFF;
        spi_byte({a[4:0], ext ? 3'b110 : cmd}, r);
        hdr_rx[1] = r;
        if (ext) begin
            spi_byte({a[15:13], cmd, res}, r);
            hdr_rx[2] = r;
        end
        for (int i = 0; i < n; i++) begin
            spi_byte(tx_buf[i], r);
            rx_buf[i] = r;
        end
        if (tail > 0) spi_bits(8'hA5, tail);
        cs_end();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog all requirements got=timeout exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int w0, r0;
        logic [15:0] a;
        repeat (4) @(negedge clk);
        check("R12 reset miso", miso, 0);
        check("R12 reset bus_req", bus_req, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R12 idle miso", miso, 0);

        // R5 R6 R1: two-byte read with interrupt snapshot
        irq_flags = 24'hC396A5;
        for (int i = 0; i < 8; i++) tx_buf[i] = 8'h00;
        w0 = n_wr;
        run_frame(1'b0, 16'h1ABC, 3'b010, 2'b00, 4, 0);
        check("R5 irq byte0", hdr_rx[0], irq_start[7:0]);
        check("R5 irq byte1 snapshot", hdr_rx[1], irq_start[15:8]);
        for (int i = 0; i < 4; i++)
            check("R6 R1 read burst", rx_buf[i], model_rd(16'h1ABC + 16'(i)));
        check("R6 no writes on read", n_wr - w0, 0);

        // R2 R8 R9 R7: all command codes in the short header
        for (int c = 0; c < 8; c++) begin
            if (c == 6) continue;
            a = 16'h0100 + 16'(c * 37);
            for (int i = 0; i < 3; i++) tx_buf[i] = 8'hE0 + 8'(c * 3 + i);
            w0 = n_wr;
            r0 = n_rd;
            run_frame(1'b0, a, 3'(c), 2'b00, 3, 0);
            if (c == 2) begin
                for (int i = 0; i < 3; i++)
                    check("R2 read code", rx_buf[i], model_rd(a + 16'(i)));
                check("R2 read code no write", n_wr - w0, 0);
            end else if (c == 4) begin
                check("R7 R11 write count", n_wr - w0, 3);
                for (int i = 0; i < 3; i++) begin
                    check("R7 write addr", wr_addr_log[w0 + i], a + 16'(i));
                    check("R7 write data", wr_data_log[w0 + i], tx_buf[i]);
                    check("R9 miso zero on write", rx_buf[i], 0);
                end
            end else begin
                check("R8 no read access", n_rd - r0, 0);
                check("R8 no write access", n_wr - w0, 0);
                for (int i = 0; i < 3; i++)
                    check("R8 miso zero", rx_buf[i], 0);
            end
        end

        // R2 R4: walking address bit, short then extended header
        for (int k = 0; k < 16; k++) begin
            a = 16'h1 << k;
            run_frame(k >= 13, a, 3'b010, 2'b00, 2, 0);
            check("R2 R4 addr bit byte0", rx_buf[0], model_rd(a));
            check("R2 R4 addr bit byte1", rx_buf[1], model_rd(a + 16'd1));
        end

        // R3: short header ignores bits [15:13]
        run_frame(1'b0, 16'hE123, 3'b010, 2'b00, 1, 0);
        check("R3 upper bits forced zero", rx_buf[0], model_rd(16'h0123));

        // R4 R5 R6: extended read wrapping past 0xFFFF
        irq_flags = 24'h5E7D1B;
        run_frame(1'b1, 16'hFFFE, 3'b010, 2'b00, 4, 0);
        check("R5 ext irq byte0", hdr_rx[0], irq_start[7:0]);
        check("R5 ext irq byte1", hdr_rx[1], irq_start[15:8]);
        check("R5 ext irq byte2", hdr_rx[2], irq_start[23:16]);
        for (int i = 0; i < 4; i++)
            check("R6 R4 wrap read", rx_buf[i], model_rd(16'hFFFE + 16'(i)));

        // R7: partial byte at deselect is dropped
        tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'h33;
        w0 = n_wr;
        run_frame(1'b0, 16'h0010, 3'b100, 2'b00, 3, 5);
        check("R7 partial dropped count", n_wr - w0, 3);
        check("R7 last full addr", wr_addr_log[w0 + 2], 16'h0012);

        // R7 R4: extended write wrapping
        tx_buf[0] = 8'hAB; tx_buf[1] = 8'hCD;
        w0 = n_wr;
        run_frame(1'b1, 16'hFFFF, 3'b100, 2'b00, 2, 0);
        check("R7 ext write count", n_wr - w0, 2);
        check("R7 ext write addr0", wr_addr_log[w0], 16'hFFFF);
        check("R7 ext write wrap addr1", wr_addr_log[w0 + 1], 16'h0000);
        check("R7 ext write data1", wr_data_log[w0 + 1], 8'hCD);

        // R4: reserved bits nonzero, and nested extend code
        w0 = n_wr; r0 = n_rd;
        run_frame(1'b1, 16'h4000, 3'b010, 2'b01, 2, 0);
        check("R4 bad reserved no read", n_rd - r0, 0);
        check("R4 bad reserved miso", rx_buf[0], 0);
        tx_buf[0] = 8'h77; tx_buf[1] = 8'h88;
        run_frame(1'b1, 16'h4000, 3'b100, 2'b10, 2, 0);
        check("R4 bad reserved no write", n_wr - w0, 0);
        r0 = n_rd;
        run_frame(1'b1, 16'h6000, 3'b110, 2'b00, 2, 0);
        check("R4 R8 nested extend no access", (n_rd - r0) + (n_wr - w0), 0);
        check("R8 nested extend miso", rx_buf[1], 0);

        // R10: abort mid-header then a fresh frame
        for (int t = 0; t < 2; t++) begin
            logic [7:0] r;
            irq_flags = 24'h0F0F33 + 24'(t);
            w0 = n_wr;
            cs_begin();
            spi_byte(8'h80, r);
            if (t == 1) spi_byte(8'h04, r);
            spi_bits(8'hFF, 4);
            cs_end();
            check("R10 abort no write", n_wr - w0, 0);
            run_frame(1'b0, 16'h0042, 3'b010, 2'b00, 2, 0);
            check("R10 restart irq byte0", hdr_rx[0], irq_start[7:0]);
            check("R10 restart read0", rx_buf[0], model_rd(16'h0042));
            check("R10 restart read1", rx_buf[1], model_rd(16'h0043));
        end

        check("R12 final miso", miso, 0);
        check("R12 final bus_req", bus_req, 0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule